// File: doc/BRIEF.md
# Display Controller Bring-Up Sequencer

This block is a host-side state machine. After reset, on a start pulse, it brings up a display controller that sits on an SPI link. It does this by driving a byte-level SPI transaction port through one fixed run of frames:

- It wakes the controller with two short commands: switch to the external clock, then enter the active state.
- It waits a programmable settling time.
- It programs the panel timing registers.
- It loads a three-word starting display list and asks for a list swap at the next frame boundary.
- It turns on the backlight by setting bit 7 in the GPIO direction register and then in the GPIO data register. Each is a read-modify-write that keeps the other bits.
- Its last write is the pixel-clock divider. Video starts only after that write.

The SPI rate select (`spi_fast`) stays on the slow setting for the whole run. It rises only once the run has finished.

The port is byte-wide. The sequencer presents a byte and holds it until the engine acknowledges it, and it marks the last byte of each frame so the engine can release chip select. A fault from the engine stops the run in an error state. The next start pulse clears the error and begins again from the first command.

Top module: `disp_bringup_seq`

## Requirements
- R1: While reset is applied and after its release, `busy`, `done`, `error`, `spi_fast` and `sb_req` are all low until a start pulse arrives.
- R2: Frame formats are as follows. A command is 3 bytes. A write is a 3-byte address, most significant byte first, with address bits [23:22] forced to 2'b10, followed by the data bytes least significant first. A read is a 3-byte address with bits [23:22] forced to 2'b00, one dummy byte 0x00, and one data byte sent as 0x00. `sb_last` is high on exactly the final byte of each frame.
- R3: The first two frames are commands {0x44,0x00,0x00} (external clock) and then {0x00,0x00,0x00} (go active).
- R4: At least `WAIT_CYCLES` clock cycles pass between the acknowledge of the final byte of the go-active command and the next `sb_req`.
- R5: Timing writes use register address 0x102400+4*n. They go out in this order, with (n, value, data bytes): (0,548,2) (1,43,2) (2,0,2) (3,41,2) (4,292,2) (5,12,2) (6,0,2) (7,10,2) (8,0,1) (9,1,1) (10,1,1) (11,480,2) (12,272,2).
- R6: Next come three 4-byte writes: 0x02000000 to 0x100000, 0x26000007 to 0x100004, and 0x00000000 to 0x100008. A 1-byte write of 0x02 to register n=13 follows them.
- R7: The backlight step is a read of register n=14, then a 1-byte write to n=14 of the read byte OR 0x80. The same read and write pair is then done for register n=15.
- R8: The final frame is a 1-byte write of 5 to register n=16. After that frame `done` rises, `busy` falls, and 24 frames have been sent in all.
- R9: `spi_fast` is low whenever a byte is transferred and is high once `done` is high.
- R10: `sb_req` and `sb_byte` hold steady from the cycle a byte is presented until `sb_ack` or `sb_fault`. No request is made during the settling wait.
- R11: An `sb_fault` sets `error`, clears `busy`, and stops all requests until the next start.
- R12: A start while `busy` is ignored. A start from the done or error state restarts the run from the first command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the bring-up run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| error | output | 1 | Run stopped by an engine fault |
| spi_fast | output | 1 | 1 selects the fast SPI clock divider |
| sb_req | output | 1 | Byte presented to the SPI engine |
| sb_byte | output | 8 | Byte to shift out |
| sb_last | output | 1 | Presented byte ends the frame |
| sb_ack | input | 1 | Engine has shifted the presented byte |
| sb_rdata | input | 8 | Byte shifted in, valid with `sb_ack` |
| sb_fault | input | 1 | Engine fault |

## Verification
The assertions take four things for granted about the engine. It pulses `sb_ack` or `sb_fault` for a single cycle. It never raises both in the same cycle. It sends no acknowledge without a pending request. It never raises `sb_fault` in the cycle that `error` is already high from an earlier fault. The bench engine model enforces these points: it answers a request only after seeing `sb_req` at a falling edge, it holds each answer for one cycle, and it waits for the next request before answering again. It spreads acknowledge latency over zero to two cycles and injects exactly one fault in the middle of a frame.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [1:0] {K_CMD, K_WR, K_RD, K_WAIT} step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic        rmw;
    logic [23:0] addr;
    logic [31:0] data;
    logic [2:0]  nbytes;
  } step_t;

  localparam int unsigned NSTEPS  = 25;
  localparam int unsigned STEP_W  = $clog2(NSTEPS);
  localparam int unsigned FLEN_W  = 3;
  localparam logic [23:0] REG_BASE = 24'h102400;
  localparam logic [23:0] DL_BASE  = 24'h100000;
  localparam logic [7:0]  CMD_EXTCLK = 8'h44;
  localparam logic [7:0]  CMD_WAKE   = 8'h00;
  localparam logic [7:0]  BL_MASK    = 8'h80;
  localparam logic [7:0]  SWAP_FRAME = 8'h02;

  function automatic logic [23:0] reg_addr(input int unsigned n);
    return REG_BASE + 24'(4 * n);
  endfunction

  function automatic step_t mk(input step_kind_e k, input logic rmw,
                               input logic [23:0] a, input logic [31:0] d,
                               input logic [2:0] n);
    step_t s;
    s.kind   = k;
    s.rmw    = rmw;
    s.addr   = a;
    s.data   = d;
    s.nbytes = n;
    return s;
  endfunction

endpackage

// File: rtl/bringup_step_table.sv
module bringup_step_table
  import bringup_pkg::*;
#(
  parameter int unsigned H_CYCLE  = 548,
  parameter int unsigned H_OFFSET = 43,
  parameter int unsigned H_SYNC0  = 0,
  parameter int unsigned H_SYNC1  = 41,
  parameter int unsigned V_CYCLE  = 292,
  parameter int unsigned V_OFFSET = 12,
  parameter int unsigned V_SYNC0  = 0,
  parameter int unsigned V_SYNC1  = 10,
  parameter int unsigned H_SIZE   = 480,
  parameter int unsigned V_SIZE   = 272,
  parameter int unsigned PCLK_DIV = 5
) (
  input  logic [STEP_W-1:0] idx,
  output step_t             stp
);

  always_comb begin
    unique case (idx)
      5'd0:  stp = mk(K_CMD,  1'b0, {CMD_EXTCLK, 16'h0}, 32'h0, 3'd0);
      5'd1:  stp = mk(K_CMD,  1'b0, {CMD_WAKE, 16'h0},   32'h0, 3'd0);
      5'd2:  stp = mk(K_WAIT, 1'b0, 24'h0,               32'h0, 3'd0);
      5'd3:  stp = mk(K_WR, 1'b0, reg_addr(0),  32'(H_CYCLE),  3'd2);
      5'd4:  stp = mk(K_WR, 1'b0, reg_addr(1),  32'(H_OFFSET), 3'd2);
      5'd5:  stp = mk(K_WR, 1'b0, reg_addr(2),  32'(H_SYNC0),  3'd2);
      5'd6:  stp = mk(K_WR, 1'b0, reg_addr(3),  32'(H_SYNC1),  3'd2);
      5'd7:  stp = mk(K_WR, 1'b0, reg_addr(4),  32'(V_CYCLE),  3'd2);
      5'd8:  stp = mk(K_WR, 1'b0, reg_addr(5),  32'(V_OFFSET), 3'd2);
      5'd9:  stp = mk(K_WR, 1'b0, reg_addr(6),  32'(V_SYNC0),  3'd2);
      5'd10: stp = mk(K_WR, 1'b0, reg_addr(7),  32'(V_SYNC1),  3'd2);
      5'd11: stp = mk(K_WR, 1'b0, reg_addr(8),  32'd0,         3'd1);
      5'd12: stp = mk(K_WR, 1'b0, reg_addr(9),  32'd1,         3'd1);
      5'd13: stp = mk(K_WR, 1'b0, reg_addr(10), 32'd1,         3'd1);
      5'd14: stp = mk(K_WR, 1'b0, reg_addr(11), 32'(H_SIZE),   3'd2);
      5'd15: stp = mk(K_WR, 1'b0, reg_addr(12), 32'(V_SIZE),   3'd2);
      5'd16: stp = mk(K_WR, 1'b0, DL_BASE,         32'h0200_0000, 3'd4);
      5'd17: stp = mk(K_WR, 1'b0, DL_BASE + 24'd4, 32'h2600_0007, 3'd4);
      5'd18: stp = mk(K_WR, 1'b0, DL_BASE + 24'd8, 32'h0000_0000, 3'd4);
      5'd19: stp = mk(K_WR, 1'b0, reg_addr(13), {24'h0, SWAP_FRAME}, 3'd1);
      5'd20: stp = mk(K_RD, 1'b0, reg_addr(14), 32'h0, 3'd1);
      5'd21: stp = mk(K_WR, 1'b1, reg_addr(14), 32'h0, 3'd1);
      5'd22: stp = mk(K_RD, 1'b0, reg_addr(15), 32'h0, 3'd1);
      5'd23: stp = mk(K_WR, 1'b1, reg_addr(15), 32'h0, 3'd1);
      default: stp = mk(K_WR, 1'b0, reg_addr(16), 32'(PCLK_DIV), 3'd1);
    endcase
  end

endmodule

// File: rtl/bringup_frame_tx.sv
module bringup_frame_tx
  import bringup_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       go,
  input  logic       abort,
  input  step_t      stp,
  input  logic       sb_ack,
  input  logic [7:0] sb_rdata,
  output logic       sb_req,
  output logic [7:0] sb_byte,
  output logic       sb_last,
  output logic       fdone
);

  logic              act_q, act_d;
  logic [FLEN_W-1:0] idx_q, idx_d;
  logic [FLEN_W-1:0] len_q, len_d;
  logic [23:0]       hdr_q, hdr_d;
  logic [31:0]       dat_q, dat_d;
  logic              rd_q, rd_d;
  logic [7:0]        rbyte_q, rbyte_d;
  logic              load_en, step_en, cap_en;

  assign sb_req  = act_q;
  assign sb_last = act_q && (idx_q == len_q - 1'b1);
  assign fdone   = act_q && sb_ack && (idx_q == len_q - 1'b1);

  always_comb begin
    unique case (idx_q)
      3'd0:    sb_byte = hdr_q[23:16];
      3'd1:    sb_byte = hdr_q[15:8];
      3'd2:    sb_byte = hdr_q[7:0];
      3'd3:    sb_byte = rd_q ? 8'h00 : dat_q[7:0];
      3'd4:    sb_byte = rd_q ? 8'h00 : dat_q[15:8];
      3'd5:    sb_byte = dat_q[23:16];
      default: sb_byte = dat_q[31:24];
    endcase
  end

  always_comb begin
    load_en = go && !act_q;
    step_en = act_q && (sb_ack || abort);
    cap_en  = fdone && rd_q;
    act_d   = act_q;
    idx_d   = idx_q;
    len_d   = len_q;
    hdr_d   = hdr_q;
    dat_d   = dat_q;
    rd_d    = rd_q;
    rbyte_d = cap_en ? sb_rdata : rbyte_q;
    if (load_en) begin
      act_d = 1'b1;
      idx_d = '0;
      rd_d  = (stp.kind == K_RD);
      dat_d = stp.rmw ? {24'h0, rbyte_q | BL_MASK} : stp.data;
      unique case (stp.kind)
        K_CMD: begin
          hdr_d = stp.addr;
          len_d = 3'd3;
        end
        K_RD: begin
          hdr_d = {2'b00, stp.addr[21:0]};
          len_d = 3'd5;
        end
        default: begin
          hdr_d = {2'b10, stp.addr[21:0]};
          len_d = 3'd3 + stp.nbytes;
        end
      endcase
    end else if (step_en) begin
      if (abort || fdone) act_d = 1'b0;
      else                idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
      rd_q    <= 1'b0;
      rbyte_q <= '0;
    end else begin
      act_q <= act_d;
      if (load_en || step_en) idx_q <= idx_d;
      if (load_en) begin
        len_q <= len_d;
        hdr_q <= hdr_d;
        dat_q <= dat_d;
        rd_q  <= rd_d;
      end
      if (cap_en) rbyte_q <= rbyte_d;
    end
  end

endmodule

// File: rtl/bringup_wait_timer.sv
module bringup_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic srst_n,
  input  logic load,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load || !expired;
    cnt_d  = load ? LOAD_V : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq
  import bringup_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 2_000_000,
  parameter int unsigned H_CYCLE  = 548,
  parameter int unsigned H_OFFSET = 43,
  parameter int unsigned H_SYNC0  = 0,
  parameter int unsigned H_SYNC1  = 41,
  parameter int unsigned V_CYCLE  = 292,
  parameter int unsigned V_OFFSET = 12,
  parameter int unsigned V_SYNC0  = 0,
  parameter int unsigned V_SYNC1  = 10,
  parameter int unsigned H_SIZE   = 480,
  parameter int unsigned V_SIZE   = 272,
  parameter int unsigned PCLK_DIV = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic       spi_fast,
  output logic       sb_req,
  output logic [7:0] sb_byte,
  output logic       sb_last,
  input  logic       sb_ack,
  input  logic [7:0] sb_rdata,
  input  logic       sb_fault
);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_XFER, S_WAIT, S_DONE, S_ERR} seq_state_e;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEPS - 1);

  logic [1:0] rst_sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  seq_state_e        st_q, st_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  step_t             cur;
  logic              go, fdone, tmr_load, tmr_exp;

  bringup_step_table #(
    .H_CYCLE(H_CYCLE), .H_OFFSET(H_OFFSET), .H_SYNC0(H_SYNC0), .H_SYNC1(H_SYNC1),
    .V_CYCLE(V_CYCLE), .V_OFFSET(V_OFFSET), .V_SYNC0(V_SYNC0), .V_SYNC1(V_SYNC1),
    .H_SIZE(H_SIZE), .V_SIZE(V_SIZE), .PCLK_DIV(PCLK_DIV)
  ) u_table (
    .idx (step_q),
    .stp (cur)
  );

  bringup_frame_tx u_frame (
    .clk      (clk),
    .srst_n   (srst_n),
    .go       (go),
    .abort    (sb_fault),
    .stp      (cur),
    .sb_ack   (sb_ack),
    .sb_rdata (sb_rdata),
    .sb_req   (sb_req),
    .sb_byte  (sb_byte),
    .sb_last  (sb_last),
    .fdone    (fdone)
  );

  bringup_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .srst_n  (srst_n),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    step_en  = 1'b0;
    go       = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          st_d    = S_ISSUE;
          step_d  = '0;
          step_en = 1'b1;
        end
      end
      S_ISSUE: begin
        if (sb_fault) begin
          st_d = S_ERR;
        end else if (cur.kind == K_WAIT) begin
          tmr_load = 1'b1;
          st_d     = S_WAIT;
        end else begin
          go   = 1'b1;
          st_d = S_XFER;
        end
      end
      S_XFER: begin
        if (sb_fault) begin
          st_d = S_ERR;
        end else if (fdone) begin
          if (step_q == LAST_STEP) begin
            st_d = S_DONE;
          end else begin
            st_d    = S_ISSUE;
            step_d  = step_q + 1'b1;
            step_en = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (sb_fault) begin
          st_d = S_ERR;
        end else if (tmr_exp) begin
          st_d    = S_ISSUE;
          step_d  = step_q + 1'b1;
          step_en = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= S_IDLE;
      step_q <= '0;
    end else begin
      st_q <= st_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign busy     = (st_q == S_ISSUE) || (st_q == S_XFER) || (st_q == S_WAIT);
  assign done     = (st_q == S_DONE);
  assign error    = (st_q == S_ERR);
  assign spi_fast = (st_q == S_DONE);

endmodule

// File: rtl/bringup_chk.sv
module bringup_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic       spi_fast,
  input logic       sb_req,
  input logic [7:0] sb_byte,
  input logic       sb_ack,
  input logic       sb_fault
);

  // R9
  fast_only_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_fast |-> done);

  // R9
  slow_while_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req |-> !spi_fast);

  // R10
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req && !sb_ack && !sb_fault) |=> (sb_req && $stable(sb_byte)));

  // R11
  error_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(sb_fault));

  // R11
  quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error || done) |-> !sb_req);

  // R8
  exclusive_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({busy, done, error}) <= 1);

endmodule

bind disp_bringup_seq bringup_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .spi_fast (spi_fast),
  .sb_req   (sb_req),
  .sb_byte  (sb_byte),
  .sb_ack   (sb_ack),
  .sb_fault (sb_fault)
);

// File: tb/tb_disp_bringup_seq.sv
module tb_disp_bringup_seq;

  localparam int unsigned WAITC = 40;
  localparam int unsigned NFR   = 24;

  // entry: {kind[1:0] 0=cmd 1=wr 2=rd 3=rmw-wr, addr[23:0], data[31:0], nbytes[2:0]}
  localparam logic [60:0] EXP [NFR] = '{
    {2'd0, 24'h440000, 32'd0,   3'd0},
    {2'd0, 24'h000000, 32'd0,   3'd0},
    {2'd1, 24'h102400, 32'd548, 3'd2},
    {2'd1, 24'h102404, 32'd43,  3'd2},
    {2'd1, 24'h102408, 32'd0,   3'd2},
    {2'd1, 24'h10240C, 32'd41,  3'd2},
    {2'd1, 24'h102410, 32'd292, 3'd2},
    {2'd1, 24'h102414, 32'd12,  3'd2},
    {2'd1, 24'h102418, 32'd0,   3'd2},
    {2'd1, 24'h10241C, 32'd10,  3'd2},
    {2'd1, 24'h102420, 32'd0,   3'd1},
    {2'd1, 24'h102424, 32'd1,   3'd1},
    {2'd1, 24'h102428, 32'd1,   3'd1},
    {2'd1, 24'h10242C, 32'd480, 3'd2},
    {2'd1, 24'h102430, 32'd272, 3'd2},
    {2'd1, 24'h100000, 32'h02000000, 3'd4},
    {2'd1, 24'h100004, 32'h26000007, 3'd4},
    {2'd1, 24'h100008, 32'h00000000, 3'd4},
    {2'd1, 24'h102434, 32'h2,   3'd1},
    {2'd2, 24'h102438, 32'd0,   3'd1},
    {2'd3, 24'h102438, 32'd0,   3'd1},
    {2'd2, 24'h10243C, 32'd0,   3'd1},
    {2'd3, 24'h10243C, 32'd0,   3'd1},
    {2'd1, 24'h102440, 32'd5,   3'd1}
  };

  logic       clk, rst_n, start;
  logic       busy, done, error, spi_fast;
  logic       sb_req, sb_last, sb_ack, sb_fault;
  logic [7:0] sb_byte, sb_rdata;

  int total, bad;
  int cyc;
  int fc, cur_len, fault_frame;
  logic [7:0]  dir_val, gpio_val;
  logic [63:0] cap_b [32];
  int          cap_len [32];
  logic [63:0] cur_b;
  int t1, t2, fast_viol, hold_viol, req_cnt;
  logic prev_hold;
  logic [7:0] prev_byte;

  disp_bringup_seq #(.WAIT_CYCLES(WAITC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .error(error), .spi_fast(spi_fast),
    .sb_req(sb_req), .sb_byte(sb_byte), .sb_last(sb_last),
    .sb_ack(sb_ack), .sb_rdata(sb_rdata), .sb_fault(sb_fault)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // SPI engine model and frame monitor
  initial begin
    sb_ack = 1'b0; sb_fault = 1'b0; sb_rdata = 8'h00;
    prev_hold = 1'b0; prev_byte = 8'h00;
    forever begin
      @(negedge clk);
      if (sb_req && !sb_ack && !sb_fault) req_cnt++;
      if (prev_hold && (!sb_req || sb_byte != prev_byte)) hold_viol++;
      if (sb_ack || sb_fault) begin
        sb_ack = 1'b0; sb_fault = 1'b0;
        prev_hold = 1'b0;
      end else if (sb_req) begin
        if (fc == 2 && cur_len == 0 && t2 == 0) t2 = cyc;
        if ((cyc % 3) != 0) begin
          prev_hold = 1'b1;
          prev_byte = sb_byte;
        end else if (fc == fault_frame && cur_len == 1) begin
          sb_fault = 1'b1;
          prev_hold = 1'b0;
        end else begin
          sb_ack = 1'b1;
          prev_hold = 1'b0;
          sb_rdata = (fc == 19) ? dir_val : gpio_val;
          if (spi_fast) fast_viol++;
          if (cur_len < 8) cur_b[8*cur_len +: 8] = sb_byte;
          cur_len++;
          if (sb_last) begin
            if (fc < 32) begin
              cap_b[fc] = cur_b;
              cap_len[fc] = cur_len;
            end
            if (fc == 1) t1 = cyc;
            fc++;
            cur_len = 0;
            cur_b = '0;
          end
        end
      end else begin
        prev_hold = 1'b0;
      end
    end
  end

  function automatic void build(input logic [60:0] e, input logic [7:0] rv,
                                output int len, output logic [63:0] b);
    logic [1:0]  k;
    logic [23:0] a, h;
    logic [31:0] d;
    int n;
    k = e[60:59]; a = e[58:35]; d = e[34:3]; n = int'(e[2:0]);
    b = '0;
    if (k == 2'd0) begin
      b[7:0] = a[23:16]; b[15:8] = a[15:8]; b[23:16] = a[7:0];
      len = 3;
    end else if (k == 2'd2) begin
      h = {2'b00, a[21:0]};
      b[7:0] = h[23:16]; b[15:8] = h[15:8]; b[23:16] = h[7:0];
      len = 5;
    end else begin
      h = {2'b10, a[21:0]};
      if (k == 2'd3) d = {24'h0, rv | 8'h80};
      b[7:0] = h[23:16]; b[15:8] = h[15:8]; b[23:16] = h[7:0];
      for (int i = 0; i < n; i++) b[24 + 8*i +: 8] = d[8*i +: 8];
      len = 3 + n;
    end
  endfunction

  task automatic clear_mon();
    fc = 0; cur_len = 0; cur_b = '0;
    t1 = 0; t2 = 0; fast_viol = 0; hold_viol = 0; req_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic full_run(input logic [7:0] dv, input logic [7:0] gv, input bit mid_start);
    int el, en; logic [63:0] eb; logic [7:0] rv; bit mid_done;
    dir_val = dv; gpio_val = gv; mid_done = 1'b0;
    clear_mon();
    pulse_start();
    chk(busy == 1'b1 && done == 1'b0, "R12", "busy after start", busy, 1);
    for (int i = 0; i < 20000 && !done && !error; i++) begin
      @(negedge clk);
      if (mid_start && !mid_done && fc == 10) begin
        start = 1'b1; @(negedge clk); start = 1'b0; mid_done = 1'b1;
      end
    end
    chk(done == 1'b1 && busy == 1'b0 && error == 1'b0, "R8", "done state", {done, busy, error}, 3'b100);
    chk(fc == NFR, mid_start ? "R12" : "R8", "frame count", fc, NFR);
    for (int f = 0; f < NFR; f++) begin
      rv = (f == 20) ? dv : gv;
      build(EXP[f], rv, el, eb);
      chk(cap_len[f] == el && cap_b[f] == eb,
          f < 2 ? "R3/R2" : f < 15 ? "R5/R2" : f < 19 ? "R6/R2" : f < 23 ? "R7/R2" : "R8/R2",
          $sformatf("frame %0d", f), cap_b[f], eb);
    end
    chk(t2 - t1 >= int'(WAITC), "R4", "settle gap", t2 - t1, WAITC);
    chk(fast_viol == 0, "R9", "fast during transfer", fast_viol, 0);
    chk(spi_fast == 1'b1, "R9", "fast after done", spi_fast, 1);
    chk(hold_viol == 0, "R10", "byte hold", hold_viol, 0);
  endtask

  initial begin
    total = 0; bad = 0; fault_frame = -1;
    dir_val = 8'h00; gpio_val = 8'h00;
    start = 1'b0; rst_n = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    chk({busy, done, error, spi_fast, sb_req} == 5'b0, "R1", "in reset",
        {busy, done, error, spi_fast, sb_req}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({busy, done, error, spi_fast, sb_req} == 5'b0, "R1", "after release",
        {busy, done, error, spi_fast, sb_req}, 0);

    // run 1: RMW with bit 7 clear, stray start while busy
    full_run(8'h03, 8'h80, 1'b1);

    // fault mid frame
    clear_mon();
    fault_frame = 5;
    pulse_start();
    for (int i = 0; i < 20000 && !error && !done; i++) @(negedge clk);
    chk(error == 1'b1 && busy == 1'b0 && done == 1'b0, "R11", "error state",
        {error, busy, done}, 3'b100);
    chk(fc == 5, "R11", "frames before fault", fc, 5);
    req_cnt = 0;
    repeat (60) @(negedge clk);
    chk(req_cnt == 0 && error == 1'b1, "R11", "quiet after fault", req_cnt, 0);
    chk(spi_fast == 1'b0, "R9", "slow in error", spi_fast, 0);
    fault_frame = -1;

    // restart from error with other GPIO contents
    full_run(8'h7C, 8'h15, 1'b0);

    // restart from done
    full_run(8'hFF, 8'h00, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule